// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the device-side command logic that owns the status register of a serial SPI memory. It samples the chip-select, serial-clock, serial-data-in and active-low write-protect pins through synchronizers clocked by the system clock. It decodes three one-byte instructions: write enable, read status and write status. It keeps five live status fields: a busy flag for the write cycle, a write-enable latch, two block-protect bits and a write-disable bit that locks the register. It drives the serial data output only while a status read is active.

A status write is accepted only in three cases. The write-enable latch must be set beforehand. The lock must not be engaged by the write-protect pin. Chip select must be released exactly on the byte boundary after the data byte. An accepted write starts a self-timed busy period, whose length in system clocks is a parameter. The new protection bits are committed only when that period ends. During the busy period only status reads are served, so the busy flag can be polled.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset every status field is 0, so a status read returns 0x00 and `miso_oe` is low.
- R2: Opcode 0x06, followed by chip select rising after exactly 8 clocks, sets the write-enable latch (bit 1).
- R3: Opcode 0x05 shifts the status byte out MSB first, with data changing on serial-clock falling edges. The byte layout is bit 7 write-disable, bits 6..4 zero, bit 3 protect-high, bit 2 protect-low, bit 1 write-enable latch, bit 0 busy. The byte repeats, refreshed, for as long as chip select stays low, and `miso_oe` is high during the read.
- R4: Opcode 0x01 is ignored when the write-enable latch is clear.
- R5: A status write whose chip-select release comes after 7 or after 9 data bits is discarded: no busy period starts and the latch is unchanged.
- R6: A valid status write holds the busy bit at 1 for exactly WRITE_CYCLES system clocks, and the status stays readable meanwhile. The protection bits keep their old values until the busy bit drops.
- R7: When the busy period ends, data bits 7, 3 and 2 are copied into the write-disable, protect-high and protect-low fields, and the write-enable latch clears. Data bits 6..4, 1 and 0 have no effect.
- R8: A status write is not executed while the write-disable bit is 1 and `wp_n` is low. It is executed when `wp_n` is high.
- R9: While busy, the write-enable and status-write instructions are ignored.
- R10: `miso_oe` is low whenever the synchronized chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in, sampled on serial-clock rise |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable; low means high impedance |

## Verification
Several rules are checked on every cycle:
- the output enable stays off while chip select is high;
- the busy period lasts exactly WRITE_CYCLES;
- the latch is clear when busy ends, and does not move while busy;
- the protection fields change only at the end of a busy period.

Other behaviour only shows up in the bench's scenarios: byte-boundary rejection, the write-enable prerequisite, the write-protect lock, the masking of unused data bits, and the serial output format.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_WREN_END,
        ST_READ,
        ST_WDATA,
        ST_WDATA_END,
        ST_DROP
    } cmd_state_e;

    typedef struct packed {
        logic srwd;
        logic bp1;
        logic bp0;
        logic wel;
        logic wip;
    } sr_fields_t;

    typedef struct packed {
        logic       set_wel;
        logic       start_write;
        logic [2:0] new_bits;   // {srwd, bp1, bp0}
    } cmd_req_t;

    function automatic logic [7:0] pack_status(input sr_fields_t s);
        return {s.srwd, 3'b000, s.bp1, s.bp0, s.wel, s.wip};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output logic cs_n_s,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic wp_n_s
);
    localparam int         NPINS   = 4;
    localparam logic [3:0] RST_VAL = 4'b1001; // {wp_n, mosi, sclk, cs_n}

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] synced;
    logic             sclk_prev;
    logic             cs_prev;

    assign raw = {wp_n, mosi, sclk, cs_n};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= synced[1];
            cs_prev   <= synced[0];
        end
    end

    assign cs_n_s    = synced[0];
    assign cs_rise   = synced[0] & ~cs_prev;
    assign sclk_rise = synced[1] & ~sclk_prev;
    assign sclk_fall = ~synced[1] & sclk_prev;
    assign mosi_s    = synced[2];
    assign wp_n_s    = synced[3];
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n_s,
    input  logic       cs_rise,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       mosi_s,
    input  logic [7:0] status,
    input  logic       busy,
    input  logic       write_allowed,
    output cmd_req_t   req,
    output logic       miso,
    output logic       miso_oe
);
    cmd_state_e state;
    logic [7:0] shreg;
    logic [2:0] bitcnt;
    logic [7:0] tx;
    logic [2:0] txcnt;
    logic [7:0] next_byte;

    assign next_byte = {shreg[6:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OPCODE;
            shreg  <= '0;
            bitcnt <= '0;
            tx     <= '0;
            txcnt  <= '0;
            miso   <= 1'b0;
            req    <= '0;
        end else begin
            req <= '0;
            if (cs_n_s) begin
                if (cs_rise) begin
                    if (state == ST_WREN_END) req.set_wel <= 1'b1;
                    if (state == ST_WDATA_END) begin
                        req.start_write <= 1'b1;
                        req.new_bits    <= {shreg[7], shreg[3], shreg[2]};
                    end
                end
                state  <= ST_OPCODE;
                bitcnt <= '0;
                txcnt  <= '0;
            end else begin
                if (sclk_rise) begin
                    unique case (state)
                        ST_OPCODE: begin
                            shreg  <= next_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                if (next_byte == OP_WREN)
                                    state <= busy ? ST_DROP : ST_WREN_END;
                                else if (next_byte == OP_RDSR)
                                    state <= ST_READ;
                                else if (next_byte == OP_WRSR)
                                    state <= (!busy && write_allowed) ? ST_WDATA : ST_DROP;
                                else
                                    state <= ST_DROP;
                            end
                        end
                        ST_WDATA: begin
                            shreg  <= next_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) state <= ST_WDATA_END;
                        end
                        ST_WREN_END, ST_WDATA_END: state <= ST_DROP;
                        ST_READ, ST_DROP: ;
                        default: state <= ST_DROP;
                    endcase
                end
                if (sclk_fall && state == ST_READ) begin
                    if (txcnt == 3'd0) begin
                        miso <= status[7];
                        tx   <= {status[6:0], 1'b0};
                    end else begin
                        miso <= tx[7];
                        tx   <= {tx[6:0], 1'b0};
                    end
                    txcnt <= txcnt + 3'd1;
                end
            end
        end
    end

    assign miso_oe = (state == ST_READ) && !cs_n_s;
endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
    import spi_sr_pkg::*;
#(
    parameter int WRITE_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_req_t   req,
    input  logic       wp_n_s,
    output logic [7:0] status,
    output logic       busy,
    output logic       write_allowed
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    sr_fields_t     sr;
    logic [2:0]     pending;
    logic [CW-1:0]  remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            pending <= '0;
            remain  <= '0;
        end else if (sr.wip) begin
            if (remain == '0) begin
                sr.wip  <= 1'b0;
                sr.wel  <= 1'b0;
                sr.srwd <= pending[2];
                sr.bp1  <= pending[1];
                sr.bp0  <= pending[0];
            end else begin
                remain <= remain - CW'(1);
            end
        end else if (req.start_write) begin
            sr.wip  <= 1'b1;
            pending <= req.new_bits;
            remain  <= CW'(WRITE_CYCLES - 1);
        end else if (req.set_wel) begin
            sr.wel <= 1'b1;
        end
    end

    assign status        = pack_status(sr);
    assign busy          = sr.wip;
    assign write_allowed = sr.wel && !(sr.srwd && !wp_n_s);
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
    import spi_sr_pkg::*;
#(
    parameter int WRITE_CYCLES = 625000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);
    logic       cs_n_s;
    logic       cs_rise;
    logic       sclk_rise;
    logic       sclk_fall;
    logic       mosi_s;
    logic       wp_n_s;
    logic [7:0] status_byte;
    logic       busy;
    logic       write_allowed;
    cmd_req_t   req;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .wp_n(wp_n),
        .cs_n_s(cs_n_s), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .mosi_s(mosi_s), .wp_n_s(wp_n_s)
    );

    spi_cmd_decoder u_dec (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .status(status_byte), .busy(busy), .write_allowed(write_allowed),
        .req(req), .miso(miso), .miso_oe(miso_oe)
    );

    spi_status_regs #(.WRITE_CYCLES(WRITE_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .req(req), .wp_n_s(wp_n_s),
        .status(status_byte), .busy(busy), .write_allowed(write_allowed)
    );
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk #(
    parameter int WRITE_CYCLES = 625000
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n_s,
    input logic       miso_oe,
    input logic [4:0] sr_bits   // {srwd, bp1, bp0, wel, wip}
);
    logic        wip;
    logic        wel;
    logic [2:0]  prot;
    logic [31:0] busy_run;

    assign wip  = sr_bits[0];
    assign wel  = sr_bits[1];
    assign prot = sr_bits[4:2];

    always_ff @(posedge clk) begin
        if (rst)      busy_run <= '0;
        else if (wip) busy_run <= busy_run + 32'd1;
        else          busy_run <= '0;
    end

    // R10
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |-> !miso_oe);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> (busy_run == 32'(WRITE_CYCLES)));

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel);

    // R7
    prot_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot) |-> $fell(wip));

    // R9
    busy_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (wip && $past(wip)) |-> $stable(wel));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .miso_oe(miso_oe),
    .sr_bits({status_byte[7], status_byte[3:0]})
);

// File: tb/spi_status_ctrl_test.sv
module spi_status_ctrl_test;
    localparam int WCYC  = 2000;
    localparam int HALF  = 8;
    localparam int SETTLE = 2600;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] data;
        logic [3:0] nbits;
        logic       wp;
        logic [7:0] expect_sr;
        logic [3:0] req;
    } row_t;

    // R4, R2, R5, R5, R7, R2, R8, R8
    localparam row_t ROWS [8] = '{
        '{8'h01, 8'h8C, 4'd8, 1'b1, 8'h00, 4'd4},
        '{8'h06, 8'h00, 4'd0, 1'b1, 8'h02, 4'd2},
        '{8'h01, 8'h8C, 4'd7, 1'b1, 8'h02, 4'd5},
        '{8'h01, 8'h8C, 4'd9, 1'b1, 8'h02, 4'd5},
        '{8'h01, 8'hFF, 4'd8, 1'b1, 8'h8C, 4'd7},
        '{8'h06, 8'h00, 4'd0, 1'b1, 8'h8E, 4'd2},
        '{8'h01, 8'h00, 4'd8, 1'b0, 8'h8E, 4'd8},
        '{8'h01, 8'h00, 4'd8, 1'b1, 8'h00, 4'd8}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;
    logic miso_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spi_status_ctrl #(.WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        mosi = b;
        wait_clks(HALF);
        r = miso;
        sclk = 1'b1;
        wait_clks(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        logic r;
        for (int i = 0; i < n; i++) xfer_bit((i < 8) ? v[7-i] : 1'b0, r);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) xfer_bit(1'b0, v[7-i]);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic cs_end();
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(4 * HALF);
    endtask

    task automatic read_status(output logic [7:0] v);
        cs_begin();
        send_bits(8'h05, 8);
        read_byte(v);
        cs_end();
    endtask

    task automatic command(input logic [7:0] op, input logic [7:0] data, input int nbits);
        cs_begin();
        send_bits(op, 8);
        if (nbits > 0) send_bits(data, nbits);
        cs_end();
    endtask

    initial begin
        logic [7:0] s;
        logic [7:0] b0, b1, b2;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(4);

        // R1 / R10: idle output enable and reset contents
        check("R10 oe idle", {7'd0, miso_oe}, 8'h00);
        read_status(s);
        check("R1 reset status", s, 8'h00);

        foreach (ROWS[i]) begin
            wp_n = ROWS[i].wp;
            command(ROWS[i].op, ROWS[i].data, int'(ROWS[i].nbits));
            wait_clks(SETTLE);
            read_status(s);
            check($sformatf("R%0d row %0d", ROWS[i].req, i), s, ROWS[i].expect_sr);
            wp_n = 1'b1;
        end

        // R3: continuous read repeats the byte, output enabled during the read
        command(8'h06, 8'h00, 0);
        cs_begin();
        send_bits(8'h05, 8);
        read_byte(b0);
        check("R3 oe during read", {7'd0, miso_oe}, 8'h01);
        read_byte(b1);
        read_byte(b2);
        cs_end();
        check("R3 first byte", b0, 8'h02);
        check("R3 second byte", b1, 8'h02);
        check("R3 third byte", b2, 8'h02);
        check("R10 oe after release", {7'd0, miso_oe}, 8'h00);

        // R6: busy is visible while the write runs, old protection retained
        command(8'h01, 8'h0C, 8);
        read_status(s);
        check("R6 busy poll", s, 8'h03);
        // R9: status write during busy is ignored
        command(8'h01, 8'h80, 8);
        read_status(s);
        check("R9 still busy", s, 8'h03);
        wait_clks(SETTLE);
        read_status(s);
        check("R9 busy write ignored / R6 done", s, 8'h0C);

        // R1: reset clears committed fields
        wait_clks(2);
        rst = 1'b1;
        wait_clks(3);
        rst = 1'b0;
        wait_clks(4);
        read_status(s);
        check("R1 status after reset", s, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule